// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers single-cycle event pulses from the device into sticky cause bits and drives one level-sensitive interrupt line to the host. The host reads the cause registers over a simple register port, enables individual causes with a mask, and acknowledges a cause by writing a one to its bit position. A second cause register collects the events of the DMA engine. Its receive, transmit and error flags also appear as read-only summary bits in the main cause register.

A programmable coalescing delay holds the interrupt back, so that several events can collect before the host is disturbed. The delay is counted in ticks of about 32 µs, which come from a clock-cycle prescaler. A high-priority DMA receive event skips that delay. A programmable periodic timer can also raise a receive cause bit at a fixed interval. The register port is combinational on reads and takes writes on the clock edge.

Top module: `coal_irq_ctrl`

## Requirements
- R1: After reset, the main cause, DMA cause and mask registers read zero, the coalescing register at offset 0x04 reads 0x0000_0040, and `irq` is low.
- R2: An event pulse on `hw_evt` bit 0, 1, 3, 6, 7, 25, 26 or 28 sets the matching main cause bit at offset 0x08 on the next edge, and the bit stays set. Pulses on any other bit of `hw_evt` set nothing.
- R3: Writing a one to a bit of the main cause (0x08) or DMA cause (0x10) register clears that bit. Writing a zero leaves it unchanged.
- R4: If an event sets a cause bit in the same cycle that the host clears it, the bit ends up set.
- R5: The DMA cause register at 0x10 holds only bits 0, 1, 16, 17, 30 and 31. In the main cause view, bit 31 is the OR of DMA bits 16, 17 and 30, bit 27 is the OR of DMA bits 0 and 1, and bit 29 equals DMA bit 31. Host writes to these three main bits have no effect.
- R6: The mask register at 0x0C reads back all 32 written bits. `irq` stays low whenever the AND of the cause view and the mask is zero.
- R7: With a coalescing delay D in bits 7:0 of 0x04 and D > 0, `irq` rises no sooner than (D−1)·TICK_CYCLES cycles and no later than D·TICK_CYCLES+3 cycles after the first enabled cause appears. With D = 0, it rises within 2 cycles.
- R8: `irq` falls as soon as no enabled cause remains. The next enabled cause starts a fresh delay.
- R9: When DMA cause bit 30 is set and mask bit 31 is set, `irq` is high on the cycle after the event, whatever the delay is.
- R10: A non-zero value P in bits 15:8 of 0x04 sets main cause bit 28 once every P ticks. P = 0 stops it. Both bytes of 0x04 read back as written.
- R11: Only offsets 0x04, 0x08, 0x0C and 0x10 are decoded. Every other offset reads zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hw_evt | input | 32 | Event pulses for the main cause register |
| dma_evt | input | 32 | Event pulses for the DMA cause register |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with TICK_CYCLES = 4, so each delay tick lasts four clock cycles. This short tick lets the bench measure the full coalescing window for delays of 0, 1 and 5 cycle by cycle. It also lets it watch several periodic intervals and show the bypass against a delay of 0xFF. The random phase leaves the mask at zero and compares both cause registers each cycle against a bench model, which covers overlapping sets and clears.

// File: rtl/icc_pkg.sv
// Package: icc_pkg
// Shared offsets, bit positions and implemented-bit masks for the
// coalescing interrupt controller. Assumes a 32-bit register width.
package icc_pkg;
    localparam int REG_W = 32;

    // register byte offsets
    localparam int OFF_COAL  = 'h04;
    localparam int OFF_CAUSE = 'h08;
    localparam int OFF_MASK  = 'h0C;
    localparam int OFF_DMA   = 'h10;

    // main cause bits that the summary logic drives
    localparam int SUM_RX  = 31;
    localparam int SUM_ERR = 29;
    localparam int SUM_TX  = 27;
    localparam int PER_BIT = 28;

    // DMA cause bit positions
    localparam int DMA_ERR   = 31;
    localparam int DMA_HIPRI = 30;
    localparam int DMA_RX1   = 17;
    localparam int DMA_RX0   = 16;
    localparam int DMA_TX1   = 1;
    localparam int DMA_TX0   = 0;

    // bits with storage in each cause register
    localparam logic [REG_W-1:0] MAIN_IMPL = 32'h1600_00CB;
    localparam logic [REG_W-1:0] DMA_IMPL  = 32'hC003_0003;
endpackage

// File: rtl/icc_tick_gen.sv
// Module: icc_tick_gen
// Divides the clock into one-cycle ticks and raises a one-cycle periodic
// event every period_i ticks. A period of zero disables the event.
// Assumes TICK_CYCLES >= 1.
module icc_tick_gen #(
    parameter int TICK_CYCLES = 3200,
    parameter int PER_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o,
    output logic             per_evt_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [PER_W-1:0] per_cnt;
    logic             per_hit;

    generate
        if (TICK_CYCLES == 1) begin : g_no_div
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);
            logic [CNT_W-1:0] div_cnt;
            // Free-running prescaler that wraps every TICK_CYCLES cycles.
            always_ff @(posedge clk) begin
                if (!rst_n)                div_cnt <= '0;
                else if (div_cnt == LAST)  div_cnt <= '0;
                else                       div_cnt <= div_cnt + 1'b1;
            end
            assign tick_o = (div_cnt == LAST);
        end
    endgenerate

    assign per_hit   = (period_i != '0) && (per_cnt >= period_i - 1'b1);
    assign per_evt_o = tick_o && per_hit;

    // Counts ticks within the current periodic interval.
    always_ff @(posedge clk) begin
        if (!rst_n || period_i == '0) per_cnt <= '0;
        else if (per_evt_o)           per_cnt <= '0;
        else if (tick_o)              per_cnt <= per_cnt + 1'b1;
    end

    // R10
    per_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt_o |=> (per_cnt == '0));
endmodule

// File: rtl/icc_w1c_reg.sv
// Module: icc_w1c_reg
// Sticky cause register: hardware pulses set bits, and the host clears them
// by writing ones. A set wins over a clear in the same cycle. Only the bits
// in IMPL hold state; the rest read zero.
module icc_w1c_reg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Update the stored bits; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_i) | set_i) & IMPL;
    end

    assign q_o = q;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(set_i & IMPL) |=> ((q & $past(set_i & IMPL)) == $past(set_i & IMPL)));

    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(q) & ~$past(clr_i)) & ~q) == '0));
endmodule

// File: rtl/icc_coalesce.sv
// Module: icc_coalesce
// Holds the interrupt back for delay_i ticks after an enabled cause appears,
// then keeps it high while any enabled cause remains. A bypass request
// raises the line at once. Assumes tick_i is a one-cycle strobe.
module icc_coalesce #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pending_i,
    input  logic               bypass_i,
    input  logic               tick_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               irq_o
);
    logic               counting;
    logic               fired;
    logic [DELAY_W-1:0] cnt;

    // Arm, count down and fire the coalescing window.
    always_ff @(posedge clk) begin
        if (!rst_n || !pending_i) begin
            counting <= 1'b0;
            fired    <= 1'b0;
            cnt      <= '0;
        end else if (!counting && !fired) begin
            if (delay_i == '0) begin
                fired <= 1'b1;
            end else begin
                counting <= 1'b1;
                cnt      <= delay_i;
            end
        end else if (counting && tick_i) begin
            if (cnt <= 1) begin
                counting <= 1'b0;
                fired    <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign irq_o = pending_i && (fired || bypass_i);

    // R7
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> (($past(counting) && $past(tick_i)) || $past(delay_i == '0)));

    // R8
    idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> (!fired && !counting));
endmodule

// File: rtl/coal_irq_ctrl.sv
// Module: coal_irq_ctrl
// Top of the coalescing host interrupt controller: register decode, the
// main and DMA cause registers, summary roll-up, mask, the periodic and
// tick generator, and the coalescing timer. Reads are combinational; writes
// take effect on the clock edge. Assumes ADDR_W >= 5.
module coal_irq_ctrl
    import icc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          TICK_CYCLES = 3200,
    parameter logic [7:0]  DELAY_RESET = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       hw_evt,
    input  logic [31:0]       dma_evt,
    output logic              irq
);
    localparam int DELAY_W = 8;
    localparam logic [ADDR_W-1:0] A_COAL  = ADDR_W'(OFF_COAL);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_DMA   = ADDR_W'(OFF_DMA);

    logic [DELAY_W-1:0] delay_q;
    logic [DELAY_W-1:0] period_q;
    logic [REG_W-1:0]   mask_q;
    logic [REG_W-1:0]   main_q, dma_q, summary, view;
    logic [REG_W-1:0]   main_set, main_clr, dma_clr;
    logic               wr_coal, wr_cause, wr_mask, wr_dma;
    logic               tick, per_evt, pending, bypass;

    assign wr_coal  = reg_wr && (reg_addr == A_COAL);
    assign wr_cause = reg_wr && (reg_addr == A_CAUSE);
    assign wr_mask  = reg_wr && (reg_addr == A_MASK);
    assign wr_dma   = reg_wr && (reg_addr == A_DMA);

    // Host-writable control registers: delay, periodic interval, mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q  <= DELAY_RESET;
            period_q <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_coal) begin
                delay_q  <= reg_wdata[7:0];
                period_q <= reg_wdata[15:8];
            end
            if (wr_mask) mask_q <= reg_wdata;
        end
    end

    icc_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES),
        .PER_W       (DELAY_W)
    ) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_i  (period_q),
        .tick_o    (tick),
        .per_evt_o (per_evt)
    );

    // Event sources for the main cause register, periodic bit included.
    always_comb begin
        main_set          = hw_evt & MAIN_IMPL;
        main_set[PER_BIT] = hw_evt[PER_BIT] | per_evt;
    end

    assign main_clr = wr_cause ? reg_wdata : '0;
    assign dma_clr  = wr_dma   ? reg_wdata : '0;

    icc_w1c_reg #(.W(REG_W), .IMPL(MAIN_IMPL)) i_main_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (main_set),
        .clr_i (main_clr),
        .q_o   (main_q)
    );

    icc_w1c_reg #(.W(REG_W), .IMPL(DMA_IMPL)) i_dma_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dma_evt),
        .clr_i (dma_clr),
        .q_o   (dma_q)
    );

    // Roll the DMA flags up into their summary positions.
    always_comb begin
        summary          = '0;
        summary[SUM_RX]  = dma_q[DMA_RX0] | dma_q[DMA_RX1] | dma_q[DMA_HIPRI];
        summary[SUM_TX]  = dma_q[DMA_TX0] | dma_q[DMA_TX1];
        summary[SUM_ERR] = dma_q[DMA_ERR];
    end

    assign view    = main_q | summary;
    assign pending = |(view & mask_q);
    assign bypass  = dma_q[DMA_HIPRI] && mask_q[SUM_RX];

    icc_coalesce #(.DELAY_W(DELAY_W)) i_coal (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .bypass_i  (bypass),
        .tick_i    (tick),
        .delay_i   (delay_q),
        .irq_o     (irq)
    );

    // Read data multiplexer over the decoded offsets.
    always_comb begin
        unique case (reg_addr)
            A_COAL:  reg_rdata = {16'h0, period_q, delay_q};
            A_CAUSE: reg_rdata = view;
            A_MASK:  reg_rdata = mask_q;
            A_DMA:   reg_rdata = dma_q;
            default: reg_rdata = '0;
        endcase
    end

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R9
    bypass_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_q[DMA_HIPRI] && mask_q[SUM_RX]) |-> irq);

    // R5
    summary_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_q[DMA_ERR] == reg_rdata[SUM_ERR]) || (reg_addr != A_CAUSE));
endmodule

// File: tb/test_coal_irq_ctrl.sv
module test_coal_irq_ctrl;
    localparam int TICK = 4;
    localparam logic [31:0] MAIN_IMPL = 32'h1600_00CB;
    localparam logic [31:0] DMA_IMPL  = 32'hC003_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] hw_evt = '0;
    logic [31:0] dma_evt = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    coal_irq_ctrl #(.ADDR_W(8), .TICK_CYCLES(TICK), .DELAY_RESET(8'h40)) i_coal_irq_ctrl (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .hw_evt, .dma_evt, .irq
    );

    function automatic logic [31:0] exp_view(logic [31:0] m, logic [31:0] d);
        logic [31:0] v = m;
        v[31] = d[16] | d[17] | d[30];
        v[27] = d[0] | d[1];
        v[29] = d[31];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        reg_wr = 0; hw_evt = '0; dma_evt = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Cycles from an event pulse until irq rises, capped at limit.
    task automatic wait_irq(int limit, output int n);
        n = 0;
        while (!irq && n < limit) begin
            @(posedge clk); #1; n++;
            hw_evt = '0; dma_evt = '0;
        end
    endtask

    task automatic coal_case(string req, logic [7:0] dly, int lo, int hi);
        int n;
        wr(8'h04, {24'h0, dly});
        wr(8'h0C, 32'h0000_0001);
        idle(3);
        hw_evt = 32'h1;
        wait_irq(hi + 10, n);
        checks++;
        if (n < lo || n > hi) begin
            errors++;
            $display("FAIL %s actual=%0d cycles expected=%0d..%0d", req, n, lo, hi);
        end
        wr(8'h08, 32'hFFFF_FFFF);
        check("R8 irq falls after clear", {31'h0, irq}, 32'h0);
        wr(8'h0C, 32'h0);
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, m_main, m_dma;
        int n;
        void'($urandom(32'd20240611));
        idle(4);
        rst_n = 1;
        #1;

        // R1 reset state
        rd(8'h04, d); check("R1 coal reset", d, 32'h0000_0040);
        rd(8'h08, d); check("R1 cause reset", d, 32'h0);
        rd(8'h0C, d); check("R1 mask reset", d, 32'h0);
        rd(8'h10, d); check("R1 dma reset", d, 32'h0);
        check("R1 irq reset", {31'h0, irq}, 32'h0);

        // R2 every hw bit pulsed; only implemented bits stick
        hw_evt = 32'hFFFF_FFFF; step(); idle(2);
        rd(8'h08, d); check("R2 implemented bits", d, MAIN_IMPL);
        // R3 write zero keeps, write one clears
        wr(8'h08, 32'h0);
        rd(8'h08, d); check("R3 write zero keeps", d, MAIN_IMPL);
        wr(8'h08, 32'h0000_00C0);
        rd(8'h08, d); check("R3 write one clears", d, MAIN_IMPL & ~32'hC0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R3 clear all", d, 32'h0);

        // R4 set and clear same cycle
        hw_evt = 32'h8; wr(8'h08, 32'h8);
        rd(8'h08, d); check("R4 set wins", d, 32'h8);
        wr(8'h08, 32'h8);

        // R5 DMA bits and summaries
        dma_evt = 32'hFFFF_FFFF; step();
        rd(8'h10, d); check("R5 dma implemented", d, DMA_IMPL);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R5 summary write ignored", d, 32'hA800_0000);
        wr(8'h10, 32'hC000_0001);
        rd(8'h08, d); check("R5 rx and tx summary", d, 32'h8800_0000);
        wr(8'h10, 32'h0003_0002);
        rd(8'h08, d); check("R5 summaries clear", d, 32'h0);

        // R6 mask readback and gating
        wr(8'h0C, 32'h5A5A_A5A5);
        rd(8'h0C, d); check("R6 mask readback", d, 32'h5A5A_A5A5);
        wr(8'h0C, 32'h0);
        wr(8'h04, 32'h0);
        hw_evt = 32'h1; step(); idle(3);
        check("R6 masked no irq", {31'h0, irq}, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF);

        // R11 undecoded offsets
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R11 undecoded reads zero", d, 32'h0);
        rd(8'h00, d); check("R11 offset zero reads zero", d, 32'h0);
        rd(8'h0C, d); check("R11 mask untouched", d, 32'h0);
        rd(8'h04, d); check("R11 coal untouched", d, 32'h0);

        // R7 coalescing windows
        coal_case("R7 delay 0", 8'd0, 1, 2);
        coal_case("R7 delay 1", 8'd1, 0, TICK + 3);
        coal_case("R7 delay 5", 8'd5, 4 * TICK, 5 * TICK + 3);
        // R8 fresh window after re-arm
        coal_case("R8 re-arm delay 5", 8'd5, 4 * TICK, 5 * TICK + 3);

        // R9 bypass with maximum delay
        wr(8'h04, 32'h0000_00FF);
        wr(8'h0C, 32'h8000_0000);
        dma_evt = 32'h0001_0000; step(); idle(20);
        check("R7 long delay holds irq", {31'h0, irq}, 32'h0);
        dma_evt = 32'h4000_0000;
        wait_irq(5, n);
        check("R9 bypass latency", n, 1);
        wr(8'h10, 32'hFFFF_FFFF);
        check("R8 irq falls on dma clear", {31'h0, irq}, 32'h0);
        wr(8'h0C, 32'h0);

        // R10 periodic cause
        wr(8'h04, 32'h0000_0305);
        rd(8'h04, d); check("R10 coal readback", d, 32'h0000_0305);
        idle(3 * TICK + 2);
        wr(8'h08, 32'hFFFF_FFFF);
        idle(3 * TICK + 2);
        rd(8'h08, d); check("R10 periodic sets bit 28", d, 32'h1000_0000);
        wr(8'h04, 32'h0000_0005);
        wr(8'h08, 32'hFFFF_FFFF);
        idle(10 * TICK);
        rd(8'h08, d); check("R10 periodic disabled", d, 32'h0);

        // R2 R3 R4 R5 random sets and clears against a model
        wr(8'h0C, 32'h0);
        m_main = '0; m_dma = '0;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] he, de, cl;
            int sel;
            he = $urandom() & $urandom();
            de = $urandom() & $urandom();
            cl = $urandom();
            sel = $urandom_range(0, 2);
            hw_evt = he; dma_evt = de;
            if (sel == 1) begin reg_wr = 1; reg_addr = 8'h08; reg_wdata = cl; end
            if (sel == 2) begin reg_wr = 1; reg_addr = 8'h10; reg_wdata = cl; end
            m_main = ((m_main & ~((sel == 1) ? cl : 32'h0)) | he) & MAIN_IMPL;
            m_dma  = ((m_dma  & ~((sel == 2) ? cl : 32'h0)) | de) & DMA_IMPL;
            step();
            rd(8'h08, d); check("R2 R3 R4 R5 random main", d, exp_view(m_main, m_dma));
            rd(8'h10, d); check("R3 R4 random dma", d, m_dma);
            check("R6 random irq low", {31'h0, irq}, 32'h0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule